// File: doc/BRIEF.md
# Watchdog Timer with Guarded Disable

This block counts ticks of a slow watchdog time base and asks for a system reset when software stops servicing it. The slow clock is modelled as a tick-enable strobe inside the system clock domain. A 3-bit select field picks one of eight timeout lengths, each a power of two. A kick strobe from the processor restarts the count. If the chosen length runs out before a kick arrives, the block raises a one-cycle reset request and starts counting again from zero.

Software reaches the block through one 8-bit control register. The register holds the select field, an enable flag and a turn-off enable flag. Writing the enable flag to 1 always works. Clearing it needs an unlock step: software first sets the turn-off enable flag, which stays set for four system clocks and then clears itself. Only a write that clears the enable flag while the turn-off enable flag is set turns the watchdog off. Such a write also clears the counter.

Top module: `wdg_guarded`

## Requirements
- R1: After reset the control register reads 0x00 and `rst_req` is low.
- R2: The read value is {3'b000, toe, en, sel}: bits 7..5 read 0 and writing them changes nothing, bit 4 is the turn-off enable flag, bit 3 is the enable flag, and bits 2..0 are the select field.
- R3: Every write loads the select field from bits 2..0. The timeout is 2^(BASE_EXP+sel) ticks, with BASE_EXP defaulting to 14.
- R4: The counter advances only on cycles with `tick_en` high while the enable flag is 1. While the enable flag is 0 the counter stays at 0 and no request is raised.
- R5: When the tick that completes the selected period is taken with no kick, `rst_req` is high for exactly one cycle, starting in the cycle after that tick's clock edge. The counter then restarts from 0.
- R6: A kick clears the counter. If a kick arrives in the same cycle as the completing tick, the kick wins and no request is raised.
- R7: A write with bit 3 = 1 sets the enable flag whatever the state of the turn-off enable flag.
- R8: A write with bit 3 = 0 while the turn-off enable flag reads 0 leaves the enable flag unchanged.
- R9: A write with bit 4 = 1 sets the turn-off enable flag. The flag then reads 1 for exactly four cycles and is cleared by hardware. Another such write restarts the four cycles. A write with bit 4 = 0 does not clear the flag.
- R10: A write with bit 3 = 0 while the turn-off enable flag reads 1 clears the enable flag and resets the counter in the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One tick of the watchdog time base |
| kick | input | 1 | Service strobe that restarts the count |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| ctrl_rd | output | 8 | Control register read value |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
Two sets of events can land on the same clock edge. In the first, a kick arrives together with the tick that would complete the period. The bench counts exactly one tick short of the period and then applies kick and tick together; it expects no request and a fresh count afterwards. In the second, a disabling write arrives on the last cycle of the unlock window or one cycle after it. This is provoked directly at window offsets four and five, and also at random under constrained random traffic. Every cycle is judged against a cycle-accurate bench model of the register and the counter.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int SEL_W    = 3;
  localparam int REG_W    = 8;
  localparam int WIN_LEN  = 4;

  typedef struct packed {
    logic             toe;
    logic             en;
    logic [SEL_W-1:0] sel;
  } wdg_ctrl_t;

  // Shift amount that picks the timeout length.
  function automatic int period_exp(input int base, input logic [SEL_W-1:0] sel);
    return base + int'(sel);
  endfunction
endpackage

// File: rtl/wdg_ctrl_reg.sv
module wdg_ctrl_reg
  import wdg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [4:0] wr_bits,
  output wdg_ctrl_t  ctrl_o,
  output logic       disable_evt_o
);
  localparam int WIN_W = $clog2(WIN_LEN);

  wdg_ctrl_t        ctrl_q;
  logic [WIN_W-1:0] win_q;

  // Named events used by the logic and by the assertions below
  logic arm_evt;
  logic dis_evt;
  logic win_end;

  assign arm_evt = wr_en && wr_bits[4];
  assign dis_evt = wr_en && !wr_bits[3] && ctrl_q.toe;
  assign win_end = ctrl_q.toe && (win_q == '0) && !arm_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      win_q  <= '0;
    end else begin
      if (wr_en) begin
        ctrl_q.sel <= wr_bits[SEL_W-1:0];
        if (wr_bits[3])   ctrl_q.en <= 1'b1;
        else if (dis_evt) ctrl_q.en <= 1'b0;
      end
      if (arm_evt) begin
        ctrl_q.toe <= 1'b1;
        win_q      <= WIN_W'(WIN_LEN - 1);
      end else if (ctrl_q.toe) begin
        if (win_q == '0) ctrl_q.toe <= 1'b0;
        else             win_q      <= win_q - 1'b1;
      end
    end
  end

  assign ctrl_o        = ctrl_q;
  assign disable_evt_o = dis_evt;

  assert_toe_selfclear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> !ctrl_q.toe);

  assert_en_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.en && wr_en && !wr_bits[3] && !ctrl_q.toe) |=> ctrl_q.en);

  assert_en_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_bits[3]) |=> ctrl_q.en);

  assert_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dis_evt |=> !ctrl_q.en);
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
  import wdg_pkg::*;
#(
  parameter int BASE_EXP = 14,
  parameter int CNT_W    = BASE_EXP + 8
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             tick_en,
  input  logic             kick,
  input  logic             clr_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             req_q;

  function automatic logic [CNT_W-1:0] last_count(input logic [SEL_W-1:0] s);
    logic [CNT_W-1:0] p;
    p = {{(CNT_W-1){1'b0}}, 1'b1} << period_exp(BASE_EXP, s);
    return p - {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  logic restart;
  logic at_end;
  logic fire;

  assign restart = !en_i || kick || clr_i;
  assign at_end  = (cnt_q >= last_count(sel_i));
  assign fire    = !restart && tick_en && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= fire;
      if (restart)      cnt_q <= '0;
      else if (tick_en) cnt_q <= at_end ? '0 : cnt_q + 1'b1;
    end
  end

  assign expire_o = req_q;

  assert_req_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);

  assert_kick_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (!req_q && cnt_q == '0));

  assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == '0 && !req_q));

  assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !tick_en && !kick && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdg_guarded.sv
module wdg_guarded
  import wdg_pkg::*;
#(
  parameter int BASE_EXP = 14
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       kick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] ctrl_rd,
  output logic       rst_req
);
  localparam int CNT_W = BASE_EXP + 8;

  wdg_ctrl_t ctrl;
  logic      dis_evt;

  wdg_ctrl_reg u_reg (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_bits       (wr_data[4:0]),
    .ctrl_o        (ctrl),
    .disable_evt_o (dis_evt)
  );

  wdg_counter #(.BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (ctrl.en),
    .sel_i    (ctrl.sel),
    .tick_en  (tick_en),
    .kick     (kick),
    .clr_i    (dis_evt),
    .expire_o (rst_req)
  );

  assign ctrl_rd = {3'b000, ctrl};

  assert_rsvd_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_data[7:5] != 3'b000)) |=>
      (ctrl_rd[7:5] == 3'b000 && ctrl_rd[2:0] == $past(wr_data[2:0])));

  assert_sel_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ctrl_rd[2:0] == $past(wr_data[2:0]));

  assert_req_needs_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(ctrl_rd[3]));
endmodule

// File: tb/test_wdg_guarded.sv
module test_wdg_guarded;
  localparam int BASE = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       kick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] ctrl_rd;
  logic       rst_req;

  always #2 clk = ~clk;

  wdg_guarded #(.BASE_EXP(BASE)) i_wdg_guarded (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .kick(kick),
    .wr_en(wr_en), .wr_data(wr_data), .ctrl_rd(ctrl_rd), .rst_req(rst_req)
  );

  int vectors = 0;
  int fails   = 0;
  int pulses  = 0;

  // Bench model of the requirements
  logic [2:0] m_sel;
  logic       m_en, m_toe, m_req;
  int         m_win, m_cnt;

  function automatic int period_ticks(input logic [2:0] s);
    return 1 << (BASE + s);
  endfunction

  function automatic logic [7:0] expect_rd();
    return {3'b000, m_toe, m_en, m_sel};
  endfunction

  task automatic model_reset();
    m_sel = 3'd0; m_en = 1'b0; m_toe = 1'b0; m_req = 1'b0; m_win = 0; m_cnt = 0;
  endtask

  task automatic model_step();
    logic dis;
    logic fire;
    dis  = wr_en && !wr_data[3] && m_toe;
    fire = m_en && tick_en && !kick && !dis && (m_cnt >= period_ticks(m_sel) - 1);
    m_req = fire;
    if (!m_en || kick || dis) m_cnt = 0;
    else if (tick_en) m_cnt = (m_cnt >= period_ticks(m_sel) - 1) ? 0 : m_cnt + 1;
    if (wr_en) begin
      m_sel = wr_data[2:0];
      if (wr_data[3]) m_en = 1'b1;
      else if (dis)   m_en = 1'b0;
    end
    if (wr_en && wr_data[4]) begin
      m_toe = 1'b1; m_win = 3;
    end else if (m_toe) begin
      if (m_win == 0) m_toe = 1'b0;
      else m_win = m_win - 1;
    end
  endtask

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    check8("R2_R7_R8_R9_R10 ctrl_rd", ctrl_rd, expect_rd());
    check8("R4_R5_R6 rst_req", {7'd0, rst_req}, {7'd0, m_req});
    if (rst_req === 1'b1) pulses++;
  endtask

  task automatic step(input logic w, input logic [7:0] d, input logic k, input logic t);
    wr_en = w; wr_data = d; kick = k; tick_en = t;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n, input logic t);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b0, t);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int p0;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check8("R1 reset ctrl_rd", ctrl_rd, 8'h00);
    check8("R1 reset rst_req", {7'd0, rst_req}, 8'h00);

    // R4: disabled, ticks do nothing
    idle(40, 1'b1);
    check8("R4 no request while disabled", 8'(pulses), 8'd0);

    // R2: reserved bits ignored, R7 enable, R3 sel=0
    step(1'b1, 8'hE8, 1'b0, 1'b0);
    check8("R2 reserved bits read zero", ctrl_rd, 8'h08);

    // R6: kick together with completing tick
    idle(period_ticks(3'd0) - 1, 1'b1);
    step(1'b0, 8'h00, 1'b1, 1'b1);
    idle(1, 1'b0);
    check8("R6 kick wins over final tick", 8'(pulses), 8'd0);

    // R5: full period without kick gives one pulse
    idle(period_ticks(3'd0), 1'b1);
    check8("R5 one pulse after period", 8'(pulses), 8'd1);
    idle(1, 1'b0);
    check8("R5 pulse lasts one cycle", {7'd0, rst_req}, 8'h00);

    // R8: clear without unlock ignored
    step(1'b1, 8'h01, 1'b0, 1'b0);
    check8("R8 ignored disable", ctrl_rd, 8'h09);

    // R9: window length, disable on 5th cycle ignored
    step(1'b1, 8'h19, 1'b0, 1'b0);
    check8("R9 toe set", ctrl_rd, 8'h19);
    idle(3, 1'b0);
    check8("R9 toe still set at 4th cycle", ctrl_rd, 8'h19);
    idle(1, 1'b0);
    check8("R9 toe cleared by hardware", ctrl_rd, 8'h09);
    step(1'b1, 8'h01, 1'b0, 1'b0);
    check8("R8 disable after window ignored", ctrl_rd, 8'h09);

    // R10: disable on 4th cycle of window, R9 write of 0 to bit 4 keeps flag
    step(1'b1, 8'h18, 1'b0, 1'b1);
    idle(2, 1'b1);
    step(1'b1, 8'h08, 1'b0, 1'b1);
    check8("R9 bit4 zero keeps toe", ctrl_rd, 8'h18);
    step(1'b1, 8'h02, 1'b0, 1'b1);
    check8("R10 disable inside window", ctrl_rd, 8'h02);

    // R3: sel=2, period 32 ticks; R10 counter reset checked by timing
    step(1'b1, 8'h0A, 1'b0, 1'b0);
    p0 = pulses;
    idle(period_ticks(3'd2) - 1, 1'b1);
    check8("R3 no pulse before period", 8'(pulses - p0), 8'd0);
    idle(1, 1'b1);
    check8("R3 pulse at period", 8'(pulses - p0), 8'd1);

    // Constrained random traffic
    for (int i = 0; i < 30000; i++) begin
      logic       w, k, t;
      logic [7:0] d;
      w = ($urandom_range(0, 99) < 2);
      k = ($urandom_range(0, 499) == 0);
      t = ($urandom_range(0, 3) != 0);
      d = 8'($urandom());
      if ($urandom_range(0, 3) != 0) d[2] = 1'b0;
      step(w, d, k, t);
    end
    check8("R5 random run produced pulses", 8'(pulses > 2), 8'd1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule